// File: doc/BRIEF.md
# Indexed Element Misalignment Fault Unit

This block sits in the address path of an indexed vector load/store engine. Each cycle it looks at one element that is waiting to be issued. It receives the element's effective virtual address, the element width code, the direction of the access, the vector length and the number of bytes still left in the access. It also receives the instruction's mask-enable flag and a mask vector taken from the mask lanes, which it reads without owning the handshake. From these it picks one of four outcomes: issue the address as it is, stall, issue an aligned-down address for an element that is masked off, or trap.

A trap is acknowledged in the cycle where the decision is made. The exception cause, the faulting address (tval) and a one-cycle kill pulse for the load or store drain path appear on registered outputs one cycle later. A misaligned element whose mask bit is off does not fault, but only when the mask of the whole vector fits in one chunk of `LANES*8` bytes. When the vector is longer than that, a misaligned element always traps.

Top module: `idx_misalign_unit`

## Requirements
- R1: An element whose address is a multiple of its size (1 << width code, codes 0..3 mean 1, 2, 4 and 8 bytes) and that carries no illegal flag gets outcome ISSUE (code 0). It is acknowledged and `addr_o` equals the input address.
- R2: A misaligned element of an unmasked instruction (`unmasked_i` high) gets outcome TRAP (code 3) and is acknowledged.
- R3: The cycle after a misalignment trap, `exc_valid_o` is high for one cycle. `exc_cause_o` is 4 for a load and 6 for a store, and `exc_tval_o` equals the faulting address.
- R4: A misaligned element gets outcome SUPPRESS (code 2) when all of these hold: the instruction is masked, `vl_i <= (LANES*8) >> width code`, the owning lane's mask is valid and the element's mask bit is 0. The element is acknowledged and `addr_o` is the address with its low width-code bits cleared. No exception follows.
- R5: The same masked, single-chunk, misaligned element with its mask bit set to 1 gets outcome TRAP.
- R6: A masked, single-chunk, misaligned element whose owning lane's mask-valid bit is low gets outcome STALL (code 1). It has no acknowledge and no exception, and the valid bits of the other lanes do not matter.
- R7: A masked, misaligned element with `vl_i` greater than `(LANES*8) >> width code` traps whatever its mask bit is.
- R8: The element index is `vl_i - (rem_len_i >> width code)`. Its mask bit is `mask_i[lane*8 + bit]`, where `lane = index % LANES` and `bit = (index / LANES) << width code`. The valid bit of that lane is `mask_valid_i[lane]`.
- R9: An element presented with `illegal_i` high traps with priority over every other rule. The cycle after, it reports cause 2 and tval 0.
- R10: `kill_load_o` pulses together with a reported exception of a load access, and `kill_store_o` pulses together with one of a store access. The two never pulse in the same cycle.
- R11: After reset, and in any cycle following one without a trap, `exc_valid_o`, `kill_load_o` and `kill_store_o` are low.
- R12: When `elem_valid_i` is low, `ack_o` is low and no exception follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| elem_valid_i | input | 1 | An element is presented |
| illegal_i | input | 1 | The access is already known to be illegal |
| vaddr_i | input | ADDR_W | Effective virtual address of the element |
| ew_i | input | 2 | Element width code (size = 1 << code bytes) |
| is_load_i | input | 1 | 1 = load, 0 = store |
| vl_i | input | VL_W | Vector length in elements |
| rem_len_i | input | VL_W+3 | Bytes remaining, including this element |
| unmasked_i | input | 1 | High when the instruction ignores the mask |
| mask_i | input | LANES*8 | Mask byte of each lane, lane k at bits 8k+7..8k |
| mask_valid_i | input | LANES | Mask byte of each lane is valid |
| outcome_o | output | 2 | 0 issue, 1 stall, 2 suppress, 3 trap |
| ack_o | output | 1 | Element consumed this cycle |
| addr_o | output | ADDR_W | Address to issue |
| exc_valid_o | output | 1 | Exception report, one cycle after the trap |
| exc_cause_o | output | 4 | Exception cause code |
| exc_tval_o | output | ADDR_W | Faulting address, or 0 for an illegal access |
| kill_load_o | output | 1 | Drain pulse for the load path |
| kill_store_o | output | 1 | Drain pulse for the store path |

## Verification
The hardest case to reach is a masked element whose mask bit sits in a lane other than lane 0, while that lane's valid bit is low and every other lane is valid. An element of index 0 and a fully valid mask never reach it. The stimulus chooses `rem_len_i` so that the element index is 5 (lane 1, bit 4). It first clears only lane 1's valid bit, which must give STALL with no acknowledge, and then presents the same element with the lane valid, which must give SUPPRESS. A vector shorter than the lane count, where only the owning lane is valid, checks that the decision does not wait on idle lanes.

// File: rtl/idx_misalign_unit.sv
module idx_misalign_unit #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  elem_valid_i,
  input  logic                  illegal_i,
  input  logic [ADDR_W-1:0]     vaddr_i,
  input  logic [1:0]            ew_i,
  input  logic                  is_load_i,
  input  logic [VL_W-1:0]       vl_i,
  input  logic [VL_W+2:0]       rem_len_i,
  input  logic                  unmasked_i,
  input  logic [LANES*8-1:0]    mask_i,
  input  logic [LANES-1:0]      mask_valid_i,
  output logic [1:0]            outcome_o,
  output logic                  ack_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  exc_valid_o,
  output logic [3:0]            exc_cause_o,
  output logic [ADDR_W-1:0]     exc_tval_o,
  output logic                  kill_load_o,
  output logic                  kill_store_o
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CHUNK  = LANES * 8;
  localparam logic [1:0] OC_ISSUE = 2'd0, OC_STALL = 2'd1, OC_SUPP = 2'd2, OC_TRAP = 2'd3;
  localparam logic [3:0] C_ILLEGAL = 4'd2, C_LD_MIS = 4'd4, C_ST_MIS = 4'd6;

  logic [3:0]        low_mask;
  logic              misaligned, single_chunk, lane_ok, mask_bit, masked_path;
  logic [VL_W-1:0]   elem_idx;
  logic [LANE_W-1:0] lane;
  logic [2:0]        bit_sel;
  logic              trap;

  assign low_mask     = (4'd1 << ew_i) - 4'd1;
  assign misaligned   = |(vaddr_i[3:0] & low_mask);
  assign single_chunk = (32'(vl_i) <= (CHUNK >> ew_i));
  assign elem_idx     = vl_i - VL_W'(rem_len_i >> ew_i);

  generate
    if (LANES > 1) begin : g_multi
      assign lane = elem_idx[LANE_W-1:0];
    end else begin : g_single
      assign lane = '0;
    end
  endgenerate

  assign bit_sel     = 3'((elem_idx >> LANE_W) << ew_i);
  assign lane_ok     = mask_valid_i[lane];
  assign mask_bit    = mask_i[{lane, bit_sel}];
  assign masked_path = !unmasked_i && single_chunk;

  always_comb begin
    if (illegal_i)                    outcome_o = OC_TRAP;
    else if (!misaligned)             outcome_o = OC_ISSUE;
    else if (masked_path && !lane_ok) outcome_o = OC_STALL;
    else if (masked_path && !mask_bit) outcome_o = OC_SUPP;
    else                              outcome_o = OC_TRAP;
  end

  assign ack_o  = elem_valid_i && (outcome_o != OC_STALL);
  assign addr_o = (outcome_o == OC_SUPP) ? (vaddr_i & ~ADDR_W'(low_mask)) : vaddr_i;
  assign trap   = elem_valid_i && (outcome_o == OC_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid_o  <= 1'b0;
      exc_cause_o  <= '0;
      exc_tval_o   <= '0;
      kill_load_o  <= 1'b0;
      kill_store_o <= 1'b0;
    end else begin
      exc_valid_o  <= trap;
      kill_load_o  <= trap && is_load_i;
      kill_store_o <= trap && !is_load_i;
      if (trap) begin
        exc_cause_o <= illegal_i ? C_ILLEGAL : (is_load_i ? C_LD_MIS : C_ST_MIS);
        exc_tval_o  <= illegal_i ? '0 : vaddr_i;
      end
    end
  end
endmodule

// File: rtl/idx_misalign_unit_chk.sv
module idx_misalign_unit_chk #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int VL_W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  elem_valid_i,
  input logic                  illegal_i,
  input logic [ADDR_W-1:0]     vaddr_i,
  input logic [1:0]            ew_i,
  input logic                  is_load_i,
  input logic [VL_W-1:0]       vl_i,
  input logic [VL_W+2:0]       rem_len_i,
  input logic                  unmasked_i,
  input logic [LANES*8-1:0]    mask_i,
  input logic [LANES-1:0]      mask_valid_i,
  input logic [1:0]            outcome_o,
  input logic                  ack_o,
  input logic [ADDR_W-1:0]     addr_o,
  input logic                  exc_valid_o,
  input logic [3:0]            exc_cause_o,
  input logic [ADDR_W-1:0]     exc_tval_o,
  input logic                  kill_load_o,
  input logic                  kill_store_o
);
  logic [3:0] sz_m;
  logic       mis;
  assign sz_m = (4'd1 << ew_i) - 4'd1;
  assign mis  = (vaddr_i[3:0] & sz_m) != 4'd0;

  p_issue_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_i && !illegal_i && !mis |-> outcome_o == 2'd0 && ack_o && addr_o == vaddr_i);

  p_unmasked_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_i && unmasked_i && mis |-> outcome_o == 2'd3 && ack_o);

  p_tval_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_i && !illegal_i && outcome_o == 2'd3 |=>
      exc_valid_o && exc_tval_o == $past(vaddr_i) && exc_cause_o == ($past(is_load_i) ? 4'd4 : 4'd6));

  p_suppress_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_i && outcome_o == 2'd2 |-> ack_o && (addr_o[3:0] & sz_m) == 4'd0 && !unmasked_i);

  p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_i && outcome_o == 2'd1 |-> !ack_o ##1 !exc_valid_o);

  p_illegal_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid_i && illegal_i |=> exc_valid_o && exc_cause_o == 4'd2 && exc_tval_o == '0);

  p_kill_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kill_load_o, kill_store_o}) && ((kill_load_o || kill_store_o) == exc_valid_o));

  p_idle_no_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !elem_valid_i |-> !ack_o ##1 !exc_valid_o);
endmodule

bind idx_misalign_unit idx_misalign_unit_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .VL_W(VL_W)) chk_i (.*);

// File: tb/idx_misalign_unit_tb_top.sv
module idx_misalign_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4, ADDR_W = 32, VL_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic elem_valid_i = 0, illegal_i = 0, is_load_i = 0, unmasked_i = 0;
  logic [ADDR_W-1:0] vaddr_i = '0;
  logic [1:0] ew_i = '0;
  logic [VL_W-1:0] vl_i = '0;
  logic [VL_W+2:0] rem_len_i = '0;
  logic [LANES*8-1:0] mask_i = '0;
  logic [LANES-1:0] mask_valid_i = '0;
  logic [1:0] outcome_o;
  logic ack_o, exc_valid_o, kill_load_o, kill_store_o;
  logic [ADDR_W-1:0] addr_o, exc_tval_o;
  logic [3:0] exc_cause_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_misalign_unit #(.LANES(LANES), .ADDR_W(ADDR_W), .VL_W(VL_W)) dut_i (.*);

  typedef struct {
    string req;
    logic [1:0] oc; logic ack; logic [ADDR_W-1:0] addr;
    logic ev; logic [3:0] cause; logic [ADDR_W-1:0] tval; logic kl, ks;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input string req, input bit ev, input bit ill, input logic [31:0] a,
                       input int ew, input bit ld, input int vl, input int rem, input bit unm,
                       input logic [31:0] m, input logic [3:0] mv);
    exp_t e;
    int sz, idx, lane, bpos;
    bit mis, single, lok, mb;
    @(negedge clk);
    elem_valid_i = ev; illegal_i = ill; vaddr_i = a; ew_i = 2'(ew); is_load_i = ld;
    vl_i = VL_W'(vl); rem_len_i = (VL_W+3)'(rem); unmasked_i = unm; mask_i = m; mask_valid_i = mv;
    sz = 1 << ew;
    mis = (a % sz) != 0;
    idx = vl - (rem >> ew);
    single = vl <= (32 >> ew);
    lane = idx % LANES;
    bpos = ((idx / LANES) * sz) % 8;
    lok = mv[lane];
    mb = m[lane*8 + bpos];
    e.req = req; e.addr = a;
    if (ill) e.oc = 3;
    else if (!mis) e.oc = 0;
    else if (!unm && single && !lok) e.oc = 1;
    else if (!unm && single && !mb) begin e.oc = 2; e.addr = a & ~(sz - 1); end
    else e.oc = 3;
    e.ack = ev && e.oc != 1;
    e.ev = ev && e.oc == 3;
    e.cause = ill ? 4'd2 : (ld ? 4'd4 : 4'd6);
    e.tval = ill ? 0 : a;
    e.kl = e.ev && ld; e.ks = e.ev && !ld;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        check(ack_o == e.ack, e.req, "ack", ack_o, e.ack);
        if (e.ack) begin
          check(outcome_o == e.oc, e.req, "outcome", outcome_o, e.oc);
          check(addr_o == e.addr || e.oc == 3, e.req, "addr", addr_o, e.addr);
        end else if (e.oc == 1)
          check(outcome_o == 2'd1, e.req, "outcome", outcome_o, 1);
        #1;
        check(exc_valid_o == e.ev, e.req, "exc_valid", exc_valid_o, e.ev);
        if (e.ev) begin
          check(exc_cause_o == e.cause, e.req, "cause", exc_cause_o, e.cause);
          check(exc_tval_o == e.tval, e.req, "tval", exc_tval_o, e.tval);
        end
        check(kill_load_o == e.kl && kill_store_o == e.ks, e.req, "kill",
              {kill_load_o, kill_store_o}, {e.kl, e.ks});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check(!exc_valid_o && !kill_load_o && !kill_store_o, "R11", "reset outputs",
          {exc_valid_o, kill_load_o, kill_store_o}, 0);
    rst_n = 1;
    drive("R12", 0, 0, 32'h1001, 2, 1, 8, 32, 1, '1, '1);
    drive("R1",  1, 0, 32'h1000, 2, 1, 8, 32, 1, '1, '1);
    drive("R1",  1, 0, 32'h1003, 0, 0, 8, 8, 0, '0, '1);
    drive("R2",  1, 0, 32'h1001, 2, 1, 8, 32, 1, '1, '1);
    drive("R3",  1, 0, 32'h2003, 1, 0, 4, 8, 1, '1, '1);
    drive("R4",  1, 0, 32'h1001, 2, 1, 8, 32, 0, 32'hFFFF_FFFE, '1);
    drive("R5",  1, 0, 32'h1001, 2, 1, 8, 32, 0, 32'hFFFF_FFFF, '1);
    drive("R6",  1, 0, 32'h1005, 2, 1, 8, 12, 0, 32'hFFFF_EFFF, 4'b1101);
    drive("R8",  1, 0, 32'h1005, 2, 1, 8, 12, 0, 32'hFFFF_EFFF, 4'b1111);
    drive("R8",  1, 0, 32'h1005, 2, 0, 8, 12, 0, 32'hFFFF_FFFF, 4'b1111);
    drive("R8",  1, 0, 32'h1004, 3, 1, 4, 8, 0, 32'hFEFF_FFFF, 4'b1000);
    drive("R6",  1, 0, 32'h1002, 2, 1, 2, 4, 0, 32'h0000_0000, 4'b0010);
    drive("R6",  1, 0, 32'h1002, 2, 1, 2, 4, 0, 32'h0000_0000, 4'b0001);
    drive("R7",  1, 0, 32'h1001, 2, 1, 9, 36, 0, 32'h0, '1);
    drive("R7",  1, 0, 32'h3001, 0, 0, 40, 40, 0, 32'h0, '1);
    drive("R9",  1, 1, 32'h1000, 2, 1, 8, 32, 1, '1, '1);
    drive("R10", 1, 1, 32'h1001, 2, 0, 8, 32, 0, '0, '1);
    drive("R10", 1, 0, 32'h1006, 3, 1, 4, 16, 1, '1, '1);
    drive("R11", 1, 0, 32'h1008, 3, 1, 4, 16, 1, '1, '1);
    drive("R12", 0, 1, 32'h1001, 2, 1, 8, 32, 1, '1, '1);
    drive("R12", 0, 0, 32'h0, 0, 0, 0, 0, 1, '0, '0);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule